// File: doc/BRIEF.md
# Two-Register Accumulator Core

This block is a small execution core built around two data registers: an accumulator and one general-purpose register. Each clock edge it performs the single instruction whose four-bit code is presented on `instr_code`. Instructions move data between the data input port, the two registers and a registered output port. The arithmetic and logic instructions are addition, bitwise OR, bitwise AND and complement, and they always write their result to the accumulator.

The core does not fetch instructions, hold a program or branch. Surrounding logic supplies one code per clock. A value reaches the outside world only through the two output instructions. Each of these refreshes `data_out` and raises `out_valid` for the following cycle. The data width is a parameter, 8 bits by default.

Top module: `acc2_core`

## Requirements
- R1: While `rst_n` is low, the accumulator, the general register and `data_out` are held at zero and `out_valid` is low. This is observable through codes 4 and 3 issued after reset.
- R2: Codes 1 and 6 load the accumulator from `data_in`. The general register is unchanged.
- R3: Code 5 loads the general register from `data_in`. Code 2 copies the accumulator into the general register. Neither code changes the accumulator.
- R4: Code 4 loads `data_out` with the accumulator value from before that edge. Code 3 loads it with the general register. Neither code changes the accumulator or the general register, and `out_valid` is high in the cycle that follows either code.
- R5: Code 7 sets the accumulator to the accumulator plus the general register, modulo 2^DATA_W.
- R6: Code 8 sets the accumulator to the accumulator OR the general register. Code 9 sets it to the accumulator AND the general register.
- R7: Code 10 replaces the accumulator with its bitwise complement. Applying it twice restores the original value.
- R8: Codes 0 and 11 to 15 change neither register nor `data_out`, whatever value `data_in` carries.
- R9: `data_out` holds its value until the next code 3 or 4. `out_valid` is low in the cycle after any other code, so a single output instruction gives a pulse one cycle wide.
- R10: No instruction writes more than one of accumulator, general register and output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_code | input | 4 | Instruction executed at the coming edge |
| data_in | input | DATA_W | External operand for the load instructions |
| data_out | output | DATA_W | Registered output port |
| out_valid | output | 1 | High for one cycle after each output instruction |

## Verification
A corrupted accumulator or general register stays hidden until an output instruction reads it out. The bench therefore follows each data-changing instruction with code 4 or code 3, so that a wrong register value shows on `data_out` one edge after it arises. A bad write enable, such as a no-op that disturbs a register or an output that drifts, shows in two ways. It can move `data_out` or `out_valid` at the very next edge. It can also surface later, when the untouched register is read back.

// File: rtl/acc2_pkg.sv
package acc2_pkg;

  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] C_LDA_IN  = 4'd1;
  localparam logic [CODE_W-1:0] C_MOV_RA  = 4'd2;
  localparam logic [CODE_W-1:0] C_OUT_R   = 4'd3;
  localparam logic [CODE_W-1:0] C_OUT_A   = 4'd4;
  localparam logic [CODE_W-1:0] C_LDR_IN  = 4'd5;
  localparam logic [CODE_W-1:0] C_LDA_IN2 = 4'd6;
  localparam logic [CODE_W-1:0] C_ADD     = 4'd7;
  localparam logic [CODE_W-1:0] C_OR      = 4'd8;
  localparam logic [CODE_W-1:0] C_AND     = 4'd9;
  localparam logic [CODE_W-1:0] C_NOT     = 4'd10;

  typedef enum logic [2:0] {
    ASEL_IN  = 3'd0,
    ASEL_ADD = 3'd1,
    ASEL_OR  = 3'd2,
    ASEL_AND = 3'd3,
    ASEL_NOT = 3'd4
  } a_sel_e;

  typedef enum logic {
    RSEL_IN  = 1'b0,
    RSEL_ACC = 1'b1
  } r_sel_e;

  typedef enum logic {
    OSEL_GR  = 1'b0,
    OSEL_ACC = 1'b1
  } o_sel_e;

  typedef struct packed {
    logic   a_we;
    a_sel_e a_sel;
    logic   r_we;
    r_sel_e r_sel;
    logic   o_we;
    o_sel_e o_sel;
  } ctrl_t;

endpackage

// File: rtl/acc2_decode.sv
module acc2_decode
  import acc2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl       = '0;
    ctrl.a_sel = ASEL_IN;
    ctrl.r_sel = RSEL_IN;
    ctrl.o_sel = OSEL_GR;
    case (code)
      C_LDA_IN, C_LDA_IN2: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_sel = ASEL_IN;
      end
      C_MOV_RA: begin
        ctrl.r_we  = 1'b1;
        ctrl.r_sel = RSEL_ACC;
      end
      C_LDR_IN: begin
        ctrl.r_we  = 1'b1;
        ctrl.r_sel = RSEL_IN;
      end
      C_OUT_R: begin
        ctrl.o_we  = 1'b1;
        ctrl.o_sel = OSEL_GR;
      end
      C_OUT_A: begin
        ctrl.o_we  = 1'b1;
        ctrl.o_sel = OSEL_ACC;
      end
      C_ADD: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_sel = ASEL_ADD;
      end
      C_OR: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_sel = ASEL_OR;
      end
      C_AND: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_sel = ASEL_AND;
      end
      C_NOT: begin
        ctrl.a_we  = 1'b1;
        ctrl.a_sel = ASEL_NOT;
      end
      default: ;
    endcase
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl.a_we, ctrl.r_we, ctrl.o_we}) <= 1); // R10

endmodule

// File: rtl/acc2_alu.sv
module acc2_alu
  import acc2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  a_sel_e            a_sel,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] gr,
  input  logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] or_v;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] inv_v;

  // Modulo-2^DATA_W adder: the carry out is dropped.
  assign sum = acc + gr;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign or_v[b]  = acc[b] | gr[b];
    assign and_v[b] = acc[b] & gr[b];
    assign inv_v[b] = ~acc[b];
  end

  always_comb begin
    case (a_sel)
      ASEL_ADD: result = sum;
      ASEL_OR:  result = or_v;
      ASEL_AND: result = and_v;
      ASEL_NOT: result = inv_v;
      default:  result = ext;
    endcase
  end

endmodule

// File: rtl/acc2_state.sv
module acc2_state
  import acc2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] a_new,
  input  logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] gr_q,
  output logic [DATA_W-1:0] out_q,
  output logic              vld_q
);

  logic [DATA_W-1:0] acc_d;
  logic [DATA_W-1:0] gr_d;
  logic [DATA_W-1:0] out_d;
  logic              vld_d;

  always_comb begin
    acc_d = acc_q;
    gr_d  = gr_q;
    out_d = out_q;
    vld_d = ctrl.o_we;
    if (ctrl.a_we) acc_d = a_new;
    if (ctrl.r_we) gr_d  = (ctrl.r_sel == RSEL_ACC) ? acc_q : ext;
    if (ctrl.o_we) out_d = (ctrl.o_sel == OSEL_ACC) ? acc_q : gr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      gr_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      gr_q  <= gr_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/acc2_core.sv
module acc2_core
  import acc2_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        instr_code,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              out_valid
);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] gr_q;
  logic [DATA_W-1:0] a_new;

  acc2_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (instr_code),
    .ctrl  (ctrl)
  );

  acc2_alu #(.DATA_W(DATA_W)) u_alu (
    .a_sel  (ctrl.a_sel),
    .acc    (acc_q),
    .gr     (gr_q),
    .ext    (data_in),
    .result (a_new)
  );

  acc2_state #(.DATA_W(DATA_W)) u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .a_new (a_new),
    .ext   (data_in),
    .acc_q (acc_q),
    .gr_q  (gr_q),
    .out_q (data_out),
    .vld_q (out_valid)
  );

  logic is_out;
  logic is_nop;
  assign is_out = (instr_code == C_OUT_A) || (instr_code == C_OUT_R);
  assign is_nop = (instr_code == 4'd0) || (instr_code > C_NOT);

  AST_GR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_code != C_MOV_RA && instr_code != C_LDR_IN) |=> $stable(gr_q)); // R2
  AST_ACC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_code >= C_MOV_RA && instr_code <= C_LDR_IN) |=> $stable(acc_q)); // R3
  AST_OUT_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_code == C_OUT_A) |=> (out_valid && data_out == $past(acc_q))); // R4
  AST_OUT_FROM_GR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_code == C_OUT_R) |=> (out_valid && data_out == $past(gr_q))); // R4
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |=> ($stable(acc_q) && $stable(gr_q) && $stable(data_out))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_out |=> ($stable(data_out) && !out_valid)); // R9

endmodule

// File: tb/acc2_core_tb_top.sv
module acc2_core_tb_top;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [3:0]   instr_code;
  logic [W-1:0] data_in;
  logic [W-1:0] data_out;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  acc2_core #(.DATA_W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_code (instr_code),
    .data_in    (data_in),
    .data_out   (data_out),
    .out_valid  (out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a code at the falling edge, let it execute at the rising edge,
  // then settle 1 ns so outputs are sampled clear of the edge.
  task automatic run(input logic [3:0] code, input logic [W-1:0] din);
    @(negedge clk);
    instr_code = code;
    data_in    = din;
    @(posedge clk);
    #1;
  endtask

  task automatic show_a(input string req, input logic [W-1:0] exp);
    run(4'd4, 8'h00);
    chk(req, data_out, exp);
    chk(req, {7'd0, out_valid}, 8'd1);
  endtask

  task automatic show_r(input string req, input logic [W-1:0] exp);
    run(4'd3, 8'h00);
    chk(req, data_out, exp);
    chk(req, {7'd0, out_valid}, 8'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out", data_out, 8'h00);
    chk("R1 valid", {7'd0, out_valid}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    show_a("R1 acc zero", 8'h00);
    show_r("R1 gr zero", 8'h00);
  endtask

  task automatic t_load_acc();
    run(4'd1, 8'h5A);
    chk("R9 valid low", {7'd0, out_valid}, 8'd0);
    chk("R9 out held", data_out, 8'h00);
    show_a("R2 code1", 8'h5A);
    run(4'd6, 8'h33);
    show_a("R2 code6", 8'h33);
    show_r("R2 gr kept", 8'h00);
  endtask

  task automatic t_load_gr();
    run(4'd5, 8'hC4);
    show_a("R3 acc kept by 5", 8'h33);
    show_r("R3 code5", 8'hC4);
    run(4'd2, 8'hEE);
    show_r("R3 code2", 8'h33);
    show_a("R3 acc kept by 2", 8'h33);
  endtask

  task automatic t_add();
    run(4'd1, 8'hF0);
    run(4'd5, 8'h25);
    run(4'd7, 8'h00);
    show_a("R5 wrap sum", 8'h15);
    show_r("R5 gr kept", 8'h25);
  endtask

  task automatic t_logic();
    run(4'd1, 8'hCA);
    run(4'd5, 8'h5C);
    run(4'd8, 8'h00);
    show_a("R6 or", 8'hDE);
    run(4'd1, 8'hCA);
    run(4'd9, 8'h00);
    show_a("R6 and", 8'h48);
  endtask

  task automatic t_not();
    run(4'd1, 8'h3C);
    run(4'd10, 8'h00);
    show_a("R7 not", 8'hC3);
    run(4'd10, 8'h00);
    show_a("R7 twice", 8'h3C);
  endtask

  task automatic t_nop();
    show_a("R8 setup", 8'h3C);
    run(4'd0, 8'hFF);
    chk("R8 out held code0", data_out, 8'h3C);
    chk("R8 valid code0", {7'd0, out_valid}, 8'd0);
    for (int c = 11; c < 16; c++) begin
      run(c[3:0], 8'hFF);
      chk("R8 out held", data_out, 8'h3C);
    end
    show_a("R8 acc kept", 8'h3C);
    show_r("R8 gr kept", 8'h5C);
  endtask

  task automatic t_single_dest();
    run(4'd1, 8'h77);
    chk("R10 out untouched by load", data_out, 8'h5C);
    run(4'd2, 8'h00);
    chk("R10 out untouched by move", data_out, 8'h5C);
    show_a("R10 acc", 8'h77);
    show_r("R10 gr", 8'h77);
    run(4'd7, 8'h00);
    chk("R9 valid drops", {7'd0, out_valid}, 8'd0);
    show_r("R10 gr after add", 8'h77);
    show_a("R5 sum", 8'hEE);
  endtask

  initial begin
    instr_code = 4'd0;
    data_in    = '0;
    rst_n      = 1'b0;
    t_reset();
    t_load_acc();
    t_load_gr();
    t_add();
    t_logic();
    t_not();
    t_nop();
    t_single_dest();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule